// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, once per issue slot, which resident warp sends its next instruction down the pipe. A slot lasts four clocks, the time it takes to hand one instruction to every lane of a warp. At the last clock of each slot the scheduler looks at all resident warps. It drops the ones that wait on an outstanding memory access or that need a register result still in flight. From those left it picks the first one in round-robin order after the warp that issued last. Then it raises a one-clock issue strobe with that warp's id and program counter.

Software or a work distributor makes a warp resident by activating it with a start PC. For every warp, the front end presents the decoded fields of that warp's next instruction: two source register indices, a destination index with a write flag, a memory flag and an exit flag. A per-warp, per-register countdown holds back any instruction that reads a register written within the last few slots. A per-warp pending flag blocks the warp from the issue of a memory instruction until the matching completion pulse arrives. Interleaving other ready warps fills the slots that these stalls would otherwise waste.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset the issue strobe is low, and no strobe occurs until a warp has been activated.
- R2: Strobes are at least SLOT_CYC (4) clocks apart, and while some warp stays eligible a strobe occurs exactly every SLOT_CYC clocks.
- R3: Among eligible warps, the one picked is the first found searching upward from the last issued warp id plus one, wrapping past NUM_WARPS-1 to 0. The first search after reset starts at warp 0.
- R4: Activation loads a warp's PC. Each issue presents the warp's current PC on iss_pc and then advances that PC by one. iss_warp and iss_pc keep their values in cycles without a strobe.
- R5: In a slot where no resident warp is eligible, the strobe stays low for the whole slot.
- R6: When an issued instruction has its write flag set, a later instruction of the same warp whose source0 or source1 equals that destination issues no earlier than DEP_SLOTS (6) slots later, which is 24 clocks. It issues at exactly that slot if nothing else holds it. Sources that match no recent write cause no delay.
- R7: A register dependency in one warp does not delay any other warp.
- R8: Issuing an instruction with the memory flag set blocks that warp until a completion pulse for that warp arrives. The warp is eligible at the first slot decision after the pulse.
- R9: A completion pulse for another warp leaves a pending warp blocked.
- R10: Issuing an instruction with the exit flag set makes the warp non-resident. It never issues again until it is activated anew.
- R11: An activation naming a warp that is already resident is ignored, and the warp's PC is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate the warp named by act_warp |
| act_warp | input | WW | Warp id to activate |
| act_pc | input | PC_W | Start PC for the activated warp |
| mem_done | input | NUM_WARPS | Per-warp memory completion pulse |
| nxt_src0 | input | NUM_WARPS*RW | Per-warp first source register of next instruction |
| nxt_src1 | input | NUM_WARPS*RW | Per-warp second source register of next instruction |
| nxt_dst | input | NUM_WARPS*RW | Per-warp destination register of next instruction |
| nxt_wr | input | NUM_WARPS | Per-warp: next instruction writes nxt_dst |
| nxt_mem | input | NUM_WARPS | Per-warp: next instruction is a global-memory access |
| nxt_exit | input | NUM_WARPS | Per-warp: next instruction ends the warp |
| iss_valid | output | 1 | One-clock issue strobe |
| iss_warp | output | WW | Warp id of the issued instruction |
| iss_pc | output | PC_W | PC of the issued instruction |

## Verification
A scoreboard counter that is loaded with the wrong count or decrements at the wrong time changes the clock at which the dependent warp's strobe appears. That shows up as a gap other than 24 clocks, or as another warp taking the slot, within about six slots. A stuck pending or residency flag shows as a strobe for a warp that should be silent, or as a warp that never comes back after its completion pulse or activation. A wrong round-robin pointer shows as a different warp id on the very next strobe. Every fault that matters therefore appears at iss_valid, iss_warp and iss_pc within a few slots of the event that caused it.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Wrap an index that may run one lap past the pool size.
  function automatic int wrap_idx(int v, int n);
    return (v >= n) ? (v - n) : v;
  endfunction

endpackage

// File: rtl/wis_slot_timer.sv
module wis_slot_timer #(
  parameter int SLOT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_end
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic [CW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign slot_end = (ph_q == LAST);
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WW = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] elig,
  input  logic [WW-1:0]        last,
  output logic                 any,
  output logic [WW-1:0]        sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      int idx;
      idx = wrap_idx(int'(last) + i, NUM_WARPS);
      if (!any && elig[idx]) begin
        any = 1'b1;
        sel = WW'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 8,
  parameter int DEP_SLOTS = 6,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(DEP_SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    wr_en,
  input  logic [WW-1:0]           wr_warp,
  input  logic [RW-1:0]           wr_reg,
  input  logic [NUM_WARPS-1:0]    clr,
  input  logic [NUM_WARPS*RW-1:0] src0,
  input  logic [NUM_WARPS*RW-1:0] src1,
  output logic [NUM_WARPS-1:0]    blocked
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEP_SLOTS - 1);

  logic [NUM_WARPS*NUM_REGS-1:0] busy;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en, hit;

      assign hit = wr_en && (wr_warp == WW'(w)) && (wr_reg == RW'(r));

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (clr[w]) begin
          cnt_en = 1'b1;
          cnt_d  = '0;
        end else if (tick && hit) begin
          cnt_en = 1'b1;
          cnt_d  = LOAD;
        end else if (tick && (cnt_q != '0)) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign busy[w*NUM_REGS + r] = (cnt_q != '0);
    end

    logic [RW-1:0] s0, s1;
    assign s0 = src0[w*RW +: RW];
    assign s1 = src1[w*RW +: RW];
    assign blocked[w] = busy[w*NUM_REGS + int'(s0)] | busy[w*NUM_REGS + int'(s1)];
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 8,
  parameter int PC_W      = 16,
  parameter int SLOT_CYC  = 4,
  parameter int DEP_SLOTS = 6,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_valid,
  input  logic [WW-1:0]           act_warp,
  input  logic [PC_W-1:0]         act_pc,
  input  logic [NUM_WARPS-1:0]    mem_done,
  input  logic [NUM_WARPS*RW-1:0] nxt_src0,
  input  logic [NUM_WARPS*RW-1:0] nxt_src1,
  input  logic [NUM_WARPS*RW-1:0] nxt_dst,
  input  logic [NUM_WARPS-1:0]    nxt_wr,
  input  logic [NUM_WARPS-1:0]    nxt_mem,
  input  logic [NUM_WARPS-1:0]    nxt_exit,
  output logic                    iss_valid,
  output logic [WW-1:0]           iss_warp,
  output logic [PC_W-1:0]         iss_pc
);
  logic                 slot_end, any, fire;
  logic [WW-1:0]        sel;
  logic [NUM_WARPS-1:0] blocked, elig, act_take;

  logic [NUM_WARPS-1:0] res_q, res_d;
  logic [NUM_WARPS-1:0] pend_q, pend_d;
  logic [PC_W-1:0]      pc_q [NUM_WARPS];
  logic [PC_W-1:0]      pc_d [NUM_WARPS];
  logic [WW-1:0]        last_q, last_d;
  logic                 iv_q, iv_d;
  logic [WW-1:0]        iw_q, iw_d;
  logic [PC_W-1:0]      ip_q, ip_d;
  logic                 pc_en, out_en;

  wis_slot_timer #(.SLOT_CYC(SLOT_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end)
  );

  wis_scoreboard #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .DEP_SLOTS(DEP_SLOTS)
  ) i_sb (
    .clk(clk), .rst_n(rst_n), .tick(slot_end),
    .wr_en(fire && nxt_wr[sel]), .wr_warp(sel),
    .wr_reg(nxt_dst[int'(sel)*RW +: RW]),
    .clr(act_take), .src0(nxt_src0), .src1(nxt_src1),
    .blocked(blocked)
  );

  assign elig = res_q & ~pend_q & ~blocked;

  wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) i_pick (
    .elig(elig), .last(last_q), .any(any), .sel(sel)
  );

  assign fire = slot_end && any;

  // Activation is accepted only for a warp that is not resident.
  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++)
      act_take[w] = act_valid && (act_warp == WW'(w)) && !res_q[w];
  end

  always_comb begin
    res_d  = res_q;
    pend_d = pend_q;
    last_d = last_q;
    iw_d   = iw_q;
    ip_d   = ip_q;
    iv_d   = fire;
    out_en = fire;
    pc_en  = fire || (|act_take);
    for (int w = 0; w < NUM_WARPS; w++) pc_d[w] = pc_q[w];

    for (int w = 0; w < NUM_WARPS; w++)
      if (mem_done[w]) pend_d[w] = 1'b0;

    if (fire) begin
      pc_d[sel] = pc_q[sel] + 1'b1;
      if (nxt_mem[sel])  pend_d[sel] = 1'b1;
      if (nxt_exit[sel]) res_d[sel]  = 1'b0;
      last_d = sel;
      iw_d   = sel;
      ip_d   = pc_q[sel];
    end

    for (int w = 0; w < NUM_WARPS; w++) begin
      if (act_take[w]) begin
        res_d[w]  = 1'b1;
        pend_d[w] = 1'b0;
        pc_d[w]   = act_pc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      pend_q <= '0;
      last_q <= WW'(NUM_WARPS - 1);
      iv_q   <= 1'b0;
    end else begin
      res_q  <= res_d;
      pend_q <= pend_d;
      last_q <= last_d;
      iv_q   <= iv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iw_q <= '0;
      ip_q <= '0;
    end else if (out_en) begin
      iw_q <= iw_d;
      ip_q <= ip_d;
    end
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q[w] <= '0;
      else if (pc_en) pc_q[w] <= pc_d[w];
    end
  end

  assign iss_valid = iv_q;
  assign iss_warp  = iw_q;
  assign iss_pc    = ip_q;
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 16,
  parameter int SLOT_CYC  = 4,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int GW = $clog2(SLOT_CYC + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 act_valid,
  input logic [WW-1:0]        act_warp,
  input logic [NUM_WARPS-1:0] mem_done,
  input logic [NUM_WARPS-1:0] nxt_mem,
  input logic [NUM_WARPS-1:0] nxt_exit,
  input logic                 iss_valid,
  input logic [WW-1:0]        iss_warp,
  input logic [PC_W-1:0]      iss_pc
);
  logic                 seen_act;
  logic [GW-1:0]        gap;
  logic [NUM_WARPS-1:0] mem_s, exit_s, pend, gone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_act <= 1'b0;
      gap      <= GW'(SLOT_CYC);
      mem_s    <= '0;
      exit_s   <= '0;
      pend     <= '0;
      gone     <= '1;
    end else begin
      mem_s  <= nxt_mem;
      exit_s <= nxt_exit;
      if (act_valid) seen_act <= 1'b1;
      if (iss_valid)                gap <= '0;
      else if (gap != GW'(SLOT_CYC)) gap <= gap + 1'b1;
      for (int w = 0; w < NUM_WARPS; w++) begin
        if (mem_done[w])
          pend[w] <= 1'b0;
        else if (iss_valid && iss_warp == WW'(w) && mem_s[w])
          pend[w] <= 1'b1;
        if (act_valid && act_warp == WW'(w))
          gone[w] <= 1'b0;
        else if (iss_valid && iss_warp == WW'(w) && exit_s[w])
          gone[w] <= 1'b1;
      end
    end
  end

  a_r1_no_issue_before_activation: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> seen_act);

  a_r2_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (gap >= GW'(SLOT_CYC - 1)));

  a_r4_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> ($stable(iss_warp) && $stable(iss_pc)));

  a_r8_pending_warp_silent: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !pend[iss_warp]);

  a_r10_exited_warp_silent: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !gone[iss_warp]);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .PC_W(PC_W), .SLOT_CYC(SLOT_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_warp(act_warp),
  .mem_done(mem_done), .nxt_mem(nxt_mem), .nxt_exit(nxt_exit),
  .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_pc(iss_pc)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
  localparam int NW = 8;
  localparam int NR = 8;
  localparam int PCW = 16;
  localparam int WW = $clog2(NW);
  localparam int RW = $clog2(NR);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           act_valid;
  logic [WW-1:0]  act_warp;
  logic [PCW-1:0] act_pc;
  logic [NW-1:0]  mem_done;
  logic [NW*RW-1:0] nxt_src0, nxt_src1, nxt_dst;
  logic [NW-1:0]  nxt_wr, nxt_mem, nxt_exit;
  logic           iss_valid;
  logic [WW-1:0]  iss_warp;
  logic [PCW-1:0] iss_pc;

  logic [RW-1:0] b_s0 [NW];
  logic [RW-1:0] b_s1 [NW];
  logic [RW-1:0] b_dst [NW];

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int t_last = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      nxt_src0[w*RW +: RW] = b_s0[w];
      nxt_src1[w*RW +: RW] = b_s1[w];
      nxt_dst[w*RW +: RW]  = b_dst[w];
    end
  end

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .PC_W(PCW)) i_warp_issue_sched (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_warp(act_warp),
    .act_pc(act_pc), .mem_done(mem_done), .nxt_src0(nxt_src0),
    .nxt_src1(nxt_src1), .nxt_dst(nxt_dst), .nxt_wr(nxt_wr),
    .nxt_mem(nxt_mem), .nxt_exit(nxt_exit), .iss_valid(iss_valid),
    .iss_warp(iss_warp), .iss_pc(iss_pc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Waits for the next strobe and checks warp id and PC.
  task automatic expect_issue(input int w, input int pc, input int maxw, input string req);
    int n = 0;
    @(negedge clk);
    while (!iss_valid && n < maxw) begin
      @(negedge clk);
      n++;
    end
    check(iss_valid, req, "strobe seen", int'(iss_valid), 1);
    check(int'(iss_warp) == w, req, "warp id", int'(iss_warp), w);
    check(int'(iss_pc) == pc, req, "pc", int'(iss_pc), pc);
    t_last = cyc;
  endtask

  task automatic expect_quiet(input int ncyc, input string req);
    int seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (iss_valid) seen++;
    end
    check(seen == 0, req, "strobes while none eligible", seen, 0);
  endtask

  task automatic activate(input int w, input int pc);
    act_valid = 1'b1;
    act_warp  = WW'(w);
    act_pc    = PCW'(pc);
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  task automatic pulse_done(input int w);
    mem_done[w] = 1'b1;
    @(negedge clk);
    mem_done = '0;
  endtask

  // R1: reset state and silence before any activation.
  task automatic t_reset();
    check(iss_valid == 1'b0, "R1", "strobe in reset", int'(iss_valid), 0);
    check(iss_pc == '0, "R1", "pc in reset", int'(iss_pc), 0);
    rst_n = 1'b1;
    expect_quiet(12, "R1");
  endtask

  // R3, R4, R2: three warps interleave round-robin, one per slot; R10 exit.
  task automatic t_round_robin();
    int prev;
    int ws[6] = '{1, 3, 6, 1, 3, 6};
    int ps[6] = '{10, 20, 30, 11, 21, 31};
    for (int k = 0; k < 3; k++) begin
      nxt_wr[ws[k]] = 1'b1;
      b_dst[ws[k]]  = 3'd7;
    end
    activate(1, 10);
    activate(3, 20);
    activate(6, 30);
    for (int k = 0; k < 6; k++) begin
      prev = t_last;
      expect_issue(ws[k], ps[k], 40, "R3");
      if (k > 0) check(t_last - prev == 4, "R2", "slot gap", t_last - prev, 4);
    end
    nxt_exit[1] = 1'b1; nxt_exit[3] = 1'b1; nxt_exit[6] = 1'b1;
    expect_issue(1, 12, 8, "R4");
    expect_issue(3, 22, 8, "R4");
    expect_issue(6, 32, 8, "R4");
    nxt_exit = '0;
    nxt_wr   = '0;
    expect_quiet(20, "R10");
  endtask

  // R6, R5: lone warp waits 24 clocks for its own register result.
  task automatic t_dependency();
    int t0;
    nxt_wr[2] = 1'b1;
    b_dst[2]  = 3'd5;
    activate(2, 0);
    expect_issue(2, 0, 20, "R6");
    t0 = t_last;
    b_s0[2]   = 3'd5;
    nxt_wr[2] = 1'b0;
    expect_issue(2, 1, 40, "R6");
    check(t_last - t0 == 24, "R5", "bubbles then reissue gap", t_last - t0, 24);
  endtask

  // R7: warp 4 fills the slots while warp 2 waits on its register.
  task automatic t_cross_warp();
    int t2;
    int prev;
    nxt_wr[2] = 1'b1;
    b_dst[2]  = 3'd3;
    b_s0[2]   = 3'd1;
    activate(4, 50);
    expect_issue(4, 50, 8, "R3");
    expect_issue(2, 2, 8, "R3");
    t2 = t_last;
    b_s0[2]   = 3'd3;
    nxt_wr[2] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      prev = t_last;
      expect_issue(4, 51 + k, 8, "R7");
      check(t_last - prev == 4, "R7", "other warp keeps issuing", t_last - prev, 4);
    end
    expect_issue(2, 3, 8, "R6");
    check(t_last - t2 == 24, "R6", "dependent gap with traffic", t_last - t2, 24);
    b_s0[2] = 3'd1;
    nxt_exit[2] = 1'b1; nxt_exit[4] = 1'b1;
    expect_issue(4, 56, 8, "R10");
    expect_issue(2, 4, 8, "R10");
    nxt_exit = '0;
  endtask

  // R8, R9: memory instruction blocks until its own completion pulse.
  task automatic t_memory();
    int t0;
    nxt_mem[0] = 1'b1;
    activate(0, 100);
    expect_issue(0, 100, 12, "R8");
    nxt_mem[0] = 1'b0;
    expect_quiet(20, "R8");
    pulse_done(1);
    expect_quiet(40, "R9");
    t0 = cyc;
    pulse_done(0);
    expect_issue(0, 101, 8, "R8");
    check(t_last - t0 <= 5, "R8", "release latency", t_last - t0, 5);
  endtask

  // R11, R10, R4: reactivation rules.
  task automatic t_exit_reactivate();
    activate(0, 500);
    expect_issue(0, 102, 8, "R11");
    nxt_exit[0] = 1'b1;
    expect_issue(0, 103, 8, "R10");
    nxt_exit = '0;
    expect_quiet(20, "R10");
    activate(0, 40);
    expect_issue(0, 40, 8, "R4");
    expect_issue(0, 41, 8, "R4");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    act_valid = 1'b0;
    act_warp = '0;
    act_pc = '0;
    mem_done = '0;
    nxt_wr = '0;
    nxt_mem = '0;
    nxt_exit = '0;
    for (int w = 0; w < NW; w++) begin
      b_s0[w] = 3'd1;
      b_s1[w] = 3'd2;
      b_dst[w] = 3'd0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_round_robin();
    t_dependency();
    t_cross_warp();
    t_memory();
    t_exit_reactivate();
    summary();
    $finish;
  end
endmodule